// File: doc/BRIEF.md
# Bus slave response sequencer

This block drives the ready and response outputs of a slave on a pipelined AMBA AHB-style bus. The slave core presents, together with each address phase, how many wait states it wants and which response code it wants to give. The block watches the transfer type, the select line and the bus-wide ready signal to find the cycle in which a transfer's address phase completes. In the cycles that follow it produces that transfer's data-phase timing.

An OKAY transfer gets the requested number of wait states and then a ready cycle. A failing transfer (error, retry or split) gets its wait states and then the fixed two-cycle failure pattern. In the first cycle of that pattern ready is low and the code is already shown. In the second cycle ready is high and the code is still shown. Idle and busy transfers, and cycles in which the slave is not selected, get no wait states and an OKAY response.

The requested wait count is limited to the bus ceiling of 16. Any larger request is saturated. With no transfer in progress, and throughout reset, ready is high and the response is OKAY. A transfer may be accepted in the second cycle of a failure response, and its data phase then starts at once.

Top module: `ahb_resp_gen`

## Requirements
- R1: The response code on `resp_o` is 0 for OKAY, 1 for ERROR, 2 for RETRY and 3 for SPLIT. A failing transfer shows the code that was requested in its address phase.
- R2: Every ERROR, RETRY or SPLIT response spans exactly two cycles with the same code. `ready_o` is 0 in the first cycle and 1 in the second.
- R3: In any cycle where `resp_o` changes from OKAY to a non-OKAY code, `ready_o` is 0.
- R4: When a cycle has `ready_i` high and no accepted NONSEQ (2) or SEQ (3) transfer, the next cycle has `ready_o`=1 and `resp_o`=OKAY. This covers IDLE (0), BUSY (1) and the deselected case.
- R5: A transfer is accepted when `ready_i`, `sel_i` and `trans_i` being 2 or 3 are all present in the same cycle. If it requests N wait states (N ≤ 16) and OKAY, `ready_o` is 0 with OKAY for the next N cycles and then 1 with OKAY.
- R6: A requested wait count above 16 is treated as 16.
- R7: While `rst_ni` is low, and in the first cycle after it rises, `ready_o` is 1 and `resp_o` is OKAY. This also holds when reset is applied in the middle of a transfer.
- R8: A failing transfer with N wait states shows N cycles of `ready_o`=0 with OKAY, followed by the two-cycle response of R2.
- R9: No more than 16 consecutive cycles with `ready_o`=0 and `resp_o`=OKAY occur.
- R10: A transfer accepted in the second cycle of a failure response starts its data phase in the next cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Slave selected in this address phase |
| trans_i | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| ready_i | input | 1 | Bus-wide ready; high ends the current address phase |
| wait_req_i | input | REQ_W | Wait states requested for the transfer in its address phase |
| resp_req_i | input | 2 | Response code requested for the transfer in its address phase |
| ready_o | output | 1 | Slave ready output |
| resp_o | output | 2 | Slave response code |

## Verification
The hardest case to reach is a transfer accepted in the ready-high second cycle of a failure response. The sequencer then has to leave that failure state and load a new wait count or failure pattern in the same edge. The bench reaches it by holding a new NONSEQ request on the inputs while an error or retry completes, with the bus ready looped back from the slave output. The transfer is therefore taken on exactly the first cycle the bus permits. Wait-count saturation is driven to its boundary with requests of 16, 17 and a large value. Reset is also applied in the middle of a long wait run.

// File: rtl/ahb_resp_pkg.sv
package ahb_resp_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY  = 2'd0,
    RESP_ERROR = 2'd1,
    RESP_RETRY = 2'd2,
    RESP_SPLIT = 2'd3
  } resp_e;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  typedef enum logic [1:0] {
    PH_FREE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_FAIL1 = 2'd2,
    PH_FAIL2 = 2'd3
  } phase_e;

endpackage

// File: rtl/resp_req_capture.sv
module resp_req_capture
  import ahb_resp_pkg::*;
#(
  parameter int REQ_W    = 6,
  parameter int MAX_WAIT = 16,
  parameter int CNT_W    = $clog2(MAX_WAIT + 1)
) (
  input  logic             sel_i,
  input  logic [1:0]       trans_i,
  input  logic             ready_i,
  input  logic [REQ_W-1:0] wait_req_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] wait_sat_o
);

  localparam int ReqMax = (1 << REQ_W) - 1;

  // address phase of a real transfer completes
  assign accept_o = ready_i && sel_i &&
                    ((trans_i == TR_NONSEQ) || (trans_i == TR_SEQ));

  generate
    if (ReqMax > MAX_WAIT) begin : g_sat
      always_comb begin
        if (wait_req_i > REQ_W'(MAX_WAIT)) wait_sat_o = CNT_W'(MAX_WAIT);
        else                               wait_sat_o = wait_req_i[CNT_W-1:0];
      end
    end else begin : g_pass
      assign wait_sat_o = CNT_W'(wait_req_i);
    end
  endgenerate

endmodule

// File: rtl/resp_wait_ctr.sv
module resp_wait_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // a decrement is only ever requested on a running count
  p_dec_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i |-> cnt_q != '0);

endmodule

// File: rtl/resp_seq_fsm.sv
module resp_seq_fsm
  import ahb_resp_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ready_i,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] wait_i,
  input  logic [1:0]       code_i,
  input  logic             wait_last_i,
  output logic             ctr_load_o,
  output logic             ctr_dec_o,
  output logic             ready_o,
  output logic [1:0]       resp_o
);

  phase_e     ph_q, ph_d;
  logic [1:0] code_q;
  logic       fail_req;

  assign fail_req = (code_i != RESP_OKAY);

  always_comb begin
    ph_d      = ph_q;
    ctr_dec_o = 1'b0;
    if (accept_i) begin
      if (wait_i != '0) ph_d = PH_WAIT;
      else if (fail_req) ph_d = PH_FAIL1;
      else ph_d = PH_FREE;
    end else begin
      unique case (ph_q)
        PH_WAIT: begin
          ctr_dec_o = 1'b1;
          if (wait_last_i) ph_d = (code_q != RESP_OKAY) ? PH_FAIL1 : PH_FREE;
        end
        PH_FAIL1: ph_d = PH_FAIL2;
        PH_FAIL2: ph_d = PH_FREE;
        default:  ph_d = PH_FREE;
      endcase
    end
  end

  assign ctr_load_o = accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_FREE;
      code_q <= RESP_OKAY;
    end else begin
      ph_q <= ph_d;
      if (accept_i) code_q <= code_i;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_WAIT:  begin ready_o = 1'b0; resp_o = RESP_OKAY; end
      PH_FAIL1: begin ready_o = 1'b0; resp_o = code_q;    end
      PH_FAIL2: begin ready_o = 1'b1; resp_o = code_q;    end
      default:  begin ready_o = 1'b1; resp_o = RESP_OKAY; end
    endcase
  end

  p_fail_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o != RESP_OKAY) && !ready_o |=> ready_o && (resp_o == $past(resp_o)));

  p_fail_close_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o != RESP_OKAY) && ready_o |=> (resp_o == RESP_OKAY) || !ready_o);

  p_first_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_o != RESP_OKAY) && ($past(resp_o) == RESP_OKAY) |-> !ready_o);

  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && !accept_i |=> ready_o && (resp_o == RESP_OKAY));

  p_code_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i && (code_i != RESP_OKAY) |=> !ready_o);

endmodule

// File: rtl/ahb_resp_gen.sv
module ahb_resp_gen
  import ahb_resp_pkg::*;
#(
  parameter int REQ_W    = 6,
  parameter int MAX_WAIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [1:0]       trans_i,
  input  logic             ready_i,
  input  logic [REQ_W-1:0] wait_req_i,
  input  logic [1:0]       resp_req_i,
  output logic             ready_o,
  output logic [1:0]       resp_o
);

  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  logic             accept;
  logic [CNT_W-1:0] wait_sat;
  logic             ctr_load, ctr_dec, wait_last;

  resp_req_capture #(
    .REQ_W   (REQ_W),
    .MAX_WAIT(MAX_WAIT),
    .CNT_W   (CNT_W)
  ) u_capture (
    .sel_i     (sel_i),
    .trans_i   (trans_i),
    .ready_i   (ready_i),
    .wait_req_i(wait_req_i),
    .accept_o  (accept),
    .wait_sat_o(wait_sat)
  );

  resp_wait_ctr #(
    .CNT_W(CNT_W)
  ) u_wait_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ctr_load),
    .load_val_i(wait_sat),
    .dec_i     (ctr_dec),
    .last_o    (wait_last)
  );

  resp_seq_fsm #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready_i),
    .accept_i   (accept),
    .wait_i     (wait_sat),
    .code_i     (resp_req_i),
    .wait_last_i(wait_last),
    .ctr_load_o (ctr_load),
    .ctr_dec_o  (ctr_dec),
    .ready_o    (ready_o),
    .resp_o     (resp_o)
  );

  // consecutive OKAY wait cycles seen on the outputs
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 run_q <= '0;
    else if (!ready_o && resp_o == RESP_OKAY)    run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
    else                                         run_q <= '0;
  end

  p_wait_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= (CNT_W+1)'(MAX_WAIT));

  p_reset_idle_r7: assert property (@(posedge clk_i)
    !rst_ni |-> ready_o && (resp_o == RESP_OKAY));

  p_after_reset_r7: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> ready_o && (resp_o == RESP_OKAY));

endmodule

// File: tb/ahb_resp_gen_tb.sv
module ahb_resp_gen_tb;

  localparam int REQ_W = 6;
  localparam int MAXW  = 16;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             sel_i;
  logic [1:0]       trans_i;
  logic             ready_i;
  logic [REQ_W-1:0] wait_req_i;
  logic [1:0]       resp_req_i;
  logic             ready_o;
  logic [1:0]       resp_o;

  always #5 clk = ~clk;

  assign ready_i = ready_o;  // single slave: bus ready is this slave's ready

  ahb_resp_gen #(.REQ_W(REQ_W), .MAX_WAIT(MAXW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .trans_i(trans_i),
    .ready_i(ready_i), .wait_req_i(wait_req_i), .resp_req_i(resp_req_i),
    .ready_o(ready_o), .resp_o(resp_o)
  );

  int vectors = 0;
  int misses  = 0;
  int run     = 0;
  bit done    = 0;
  logic [2:0] expq[$];  // {ready, resp} per upcoming cycle

  task automatic compare(input string tag);
    logic [2:0] exp;
    exp = (expq.size() == 0) ? 3'b100 : expq[0];
    vectors++;
    if ({ready_o, resp_o} !== exp) begin
      misses++;
      $display("FAIL %s: ready=%b resp=%0d expected ready=%b resp=%0d",
               tag, ready_o, resp_o, exp[2], exp[1:0]);
    end
    if (!ready_o && resp_o == 2'd0) run++; else run = 0;
    if (run > MAXW) begin
      misses++;
      $display("FAIL R9: wait run=%0d expected <=%0d", run, MAXW);
    end
  endtask

  task automatic step(input logic s, input logic [1:0] t, input int w,
                      input logic [1:0] c, input string tag, output bit acc);
    int n;
    @(negedge clk);
    compare(tag);
    sel_i = s; trans_i = t; wait_req_i = REQ_W'(w); resp_req_i = c;
    acc = ready_o && s && t[1];
    if (expq.size() != 0) void'(expq.pop_front());
    if (acc) begin
      n = (w > MAXW) ? MAXW : w;
      for (int i = 0; i < n; i++) expq.push_back(3'b000);
      if (c != 2'd0) begin
        expq.push_back({1'b0, c});
        expq.push_back({1'b1, c});
      end
    end
  endtask

  task automatic issue(input logic [1:0] t, input int w, input logic [1:0] c,
                       input string tag);
    bit acc;
    acc = 0;
    while (!acc) step(1'b1, t, w, c, tag, acc);
  endtask

  task automatic idle(input int n, input logic [1:0] t, input logic s, input string tag);
    bit acc;
    for (int i = 0; i < n; i++) step(s, t, 3, 2'd1, tag, acc);
  endtask

  initial begin
    rst_ni = 1'b0; sel_i = 0; trans_i = 2'd0; wait_req_i = '0; resp_req_i = 2'd0;
    #1;
    vectors++;
    if (!(ready_o === 1'b1 && resp_o === 2'd0)) begin
      misses++; $display("FAIL R7: ready=%b resp=%0d expected ready=1 resp=0", ready_o, resp_o);
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2, 2'd0, 1'b1, "R7");

    // R4: idle, busy, deselected traffic gives zero-wait OKAY
    idle(3, 2'd0, 1'b1, "R4");
    idle(3, 2'd1, 1'b1, "R4");
    idle(3, 2'd2, 1'b0, "R4");

    // R5: OKAY transfers with various waits, back to back
    issue(2'd2, 0, 2'd0, "R5");
    issue(2'd3, 1, 2'd0, "R5");
    issue(2'd3, 3, 2'd0, "R5");
    issue(2'd2, 7, 2'd0, "R5");
    idle(2, 2'd0, 1'b1, "R5");

    // R6 / R9: saturation boundary
    issue(2'd2, 16, 2'd0, "R9");
    issue(2'd2, 17, 2'd0, "R6");
    issue(2'd2, 63, 2'd0, "R6");
    issue(2'd3, 40, 2'd1, "R6");
    idle(20, 2'd0, 1'b1, "R6");

    // R1 / R2 / R3: each failing code with zero waits
    issue(2'd2, 0, 2'd1, "R1");
    idle(3, 2'd0, 1'b1, "R2");
    issue(2'd2, 0, 2'd2, "R3");
    idle(3, 2'd0, 1'b1, "R2");
    issue(2'd2, 0, 2'd3, "R1");
    idle(3, 2'd0, 1'b1, "R2");

    // R8: failing with waits
    issue(2'd2, 4, 2'd3, "R8");
    issue(2'd2, 2, 2'd2, "R8");
    idle(2, 2'd0, 1'b1, "R8");

    // R10: new transfers taken in the second failure cycle
    issue(2'd2, 0, 2'd1, "R10");
    issue(2'd2, 0, 2'd2, "R10");
    issue(2'd3, 2, 2'd0, "R10");
    issue(2'd2, 1, 2'd1, "R10");
    issue(2'd2, 5, 2'd0, "R10");
    idle(3, 2'd0, 1'b1, "R10");

    // R7: reset in the middle of a long wait run
    issue(2'd2, 12, 2'd1, "R7");
    idle(4, 2'd0, 1'b1, "R7");
    @(negedge clk);
    rst_ni = 1'b0; sel_i = 0; trans_i = 2'd0;
    expq.delete(); run = 0;
    #1;
    vectors++;
    if (!(ready_o === 1'b1 && resp_o === 2'd0)) begin
      misses++; $display("FAIL R7: ready=%b resp=%0d expected ready=1 resp=0", ready_o, resp_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2, 2'd0, 1'b1, "R7");
    issue(2'd2, 2, 2'd2, "R7");
    idle(6, 2'd0, 1'b1, "R2");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule